// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit device virtual address into a physical address by walking a two-level table stored in memory. A request carries the virtual address and whether the access is a read or a write. The walker takes the first-level table base from a separate input when it accepts the request. It then reads the first-level entry and, if that entry is valid, the second-level entry. Both reads are single 32-bit words on a request/response memory port that allows one read at a time.

Each walk ends with one result cycle. The result is one of three kinds: a translated physical address, a page fault, or a bus error. A page fault is reported for a missing entry at either level or for a permission violation. A bus error is reported when a table read returns an error. Every result carries the original virtual address and the access type, so a fault handler can see what was refused. The walker does not cache translations. It handles one walk at a time, and its ready output tells the requester when the next walk can start.

Virtual addresses split into three fields. The upper ten bits select the first-level entry, the next ten bits select the second-level entry, and the low twelve bits are the byte offset within the page. Each table is one 4 KiB page of 1024 four-byte words.

Top module: `xlat_walker`

## Requirements
- R1: While reset is held, req_ready is 1 and both mem_rd_valid and res_valid are 0.
- R2: The first memory read of a walk goes to {dir_base[31:12], vaddr[31:22], 2'b00}. The low twelve bits of dir_base are ignored, and dir_base is sampled when the request is accepted.
- R3: The second read goes to {dte[31:12], vaddr[21:12], 2'b00}, where dte is the first-level entry. It is issued only after the first response and only when dte bit 0 (valid) is 1.
- R4: A successful walk returns res_kind 2'b00 with res_paddr = {pte[31:12], vaddr[11:0]}, where pte is the second-level entry.
- R5: A first-level entry with bit 0 clear ends the walk with res_kind 2'b01 (page fault) after exactly one memory read. The upper bits of that entry are ignored.
- R6: A second-level entry with bit 0 clear gives res_kind 2'b01, whatever its permission bits say.
- R7: In a valid second-level entry, bit 1 grants reads and bit 2 grants writes. An access without its grant gives res_kind 2'b01. Bits 11:9 and bits 8:3 do not affect the outcome.
- R8: A response with mem_rsp_err set ends the walk with res_kind 2'b10 (bus error), whatever the response data says, and no further read is issued.
- R9: req_ready is 0 from the cycle after acceptance through the single cycle in which res_valid is 1, and returns to 1 on the following cycle. Every result reports the request's vaddr and write type on res_vaddr and res_write.
- R10: Once raised, mem_rd_valid stays high with mem_rd_addr unchanged until mem_rd_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| dir_base | input | 32 | First-level table base, bits 31:12 used |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table word |
| mem_rsp_err | input | 1 | Read failed |
| res_valid | output | 1 | One-cycle result strobe |
| res_kind | output | 2 | 00 translated, 01 page fault, 10 bus error |
| res_paddr | output | 32 | Physical address, meaningful when res_kind is 00 |
| res_vaddr | output | 32 | Virtual address of the walk |
| res_write | output | 1 | Access type of the walk |

## Verification
Two outcomes can apply to the same response cycle: a failed table read and a decoded entry that would otherwise cause a fault or a further read. The bench sends error responses whose data holds a valid first-level entry, and also error responses whose data holds an invalid first-level entry. It sends the same kinds of error response at the second level. In each case it requires a bus-error result and no further memory read. A second overlap is tested separately: entries with several attribute bits set but the relevant permission bit clear. These must give a page fault, while entries with reserved bits set and permission granted must translate.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    parameter int VA_W   = 32;
    parameter int PA_W   = 32;
    parameter int WORD_W = 32;
    parameter int OFF_W  = 12;
    parameter int IDX_W  = 10;
    parameter int ENT_LG = 2;

    localparam int FRAME_W = PA_W - OFF_W;
    localparam int BIT_VALID = 0;
    localparam int BIT_RD    = 1;
    localparam int BIT_WR    = 2;

    typedef enum logic [1:0] {
        RES_OK     = 2'b00,
        RES_PFAULT = 2'b01,
        RES_BUSERR = 2'b10
    } res_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_PTE_REQ,
        ST_PTE_WAIT,
        ST_DONE
    } walk_st_e;

    typedef struct packed {
        logic [VA_W-1:0] va;
        logic            wr;
    } xlat_req_t;

    // level 0 selects the directory index, level 1 the page-table index
    function automatic logic [IDX_W-1:0] va_index(input logic [VA_W-1:0] va,
                                                  input logic level);
        return level ? va[OFF_W +: IDX_W] : va[VA_W-1 -: IDX_W];
    endfunction

    function automatic logic entry_permits(input logic [WORD_W-1:0] e,
                                           input logic wr);
        return wr ? e[BIT_WR] : e[BIT_RD];
    endfunction
endpackage

// File: rtl/xlat_entry_chk.sv
module xlat_entry_chk
    import xlat_pkg::*;
(
    input  logic [WORD_W-1:0]  data,
    input  logic               is_leaf,
    input  logic               wr,
    output logic               present,
    output logic               permitted,
    output logic [FRAME_W-1:0] frame
);
    always_comb begin
        present   = data[BIT_VALID];
        permitted = !is_leaf || entry_permits(data, wr);
        frame     = data[WORD_W-1 -: FRAME_W];
    end
endmodule

// File: rtl/xlat_ctx.sv
module xlat_ctx
    import xlat_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_req,
    input  xlat_req_t          req,
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic               ld_tbl,
    input  logic               ld_page,
    input  logic [FRAME_W-1:0] entry_frame,
    input  logic               level,
    output logic [PA_W-1:0]    rd_addr,
    output xlat_req_t          ctx,
    output logic [PA_W-1:0]    paddr
);
    logic [FRAME_W-1:0] tbl_q;
    logic [FRAME_W-1:0] page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx    <= '0;
            tbl_q  <= '0;
            page_q <= '0;
        end else begin
            if (ld_req) begin
                ctx   <= req;
                tbl_q <= dir_frame;
            end
            if (ld_tbl)
                tbl_q <= entry_frame;
            if (ld_page)
                page_q <= entry_frame;
        end
    end

    always_comb begin
        rd_addr = {tbl_q, va_index(ctx.va, level), {ENT_LG{1'b0}}};
        paddr   = {page_q, ctx.va[OFF_W-1:0]};
    end
endmodule

// File: rtl/xlat_ctl.sv
module xlat_ctl
    import xlat_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  logic      mem_rd_ready,
    input  logic      rsp_valid,
    input  logic      rsp_err,
    input  logic      present,
    input  logic      permitted,
    output logic      req_ready,
    output logic      mem_rd_valid,
    output logic      level,
    output logic      ld_req,
    output logic      ld_tbl,
    output logic      ld_page,
    output logic      res_valid,
    output res_kind_e res_kind
);
    walk_st_e  st_q, st_d;
    res_kind_e kind_q, kind_d;
    logic      waiting, rsp_hit;

    always_comb begin
        req_ready    = (st_q == ST_IDLE);
        mem_rd_valid = (st_q == ST_DIR_REQ) || (st_q == ST_PTE_REQ);
        level        = (st_q == ST_PTE_REQ) || (st_q == ST_PTE_WAIT);
        res_valid    = (st_q == ST_DONE);
        res_kind     = kind_q;
        waiting      = (st_q == ST_DIR_WAIT) || (st_q == ST_PTE_WAIT);
        rsp_hit      = waiting && rsp_valid;
        ld_req       = req_ready && req_valid;
        ld_tbl       = 1'b0;
        ld_page      = 1'b0;
        st_d         = st_q;
        kind_d       = kind_q;
        case (st_q)
            ST_IDLE:     if (req_valid) st_d = ST_DIR_REQ;
            ST_DIR_REQ:  if (mem_rd_ready) st_d = ST_DIR_WAIT;
            ST_PTE_REQ:  if (mem_rd_ready) st_d = ST_PTE_WAIT;
            ST_DIR_WAIT,
            ST_PTE_WAIT: if (rsp_valid) begin
                if (rsp_err) begin
                    kind_d = RES_BUSERR;
                    st_d   = ST_DONE;
                end else if (!present || !permitted) begin
                    kind_d = RES_PFAULT;
                    st_d   = ST_DONE;
                end else if (st_q == ST_DIR_WAIT) begin
                    ld_tbl = 1'b1;
                    st_d   = ST_PTE_REQ;
                end else begin
                    ld_page = 1'b1;
                    kind_d  = RES_OK;
                    st_d    = ST_DONE;
                end
            end
            ST_DONE:     st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            kind_q <= RES_OK;
        end else begin
            st_q   <= st_d;
            kind_q <= kind_d;
        end
    end

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    // R9
    res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> (!res_valid && req_ready));
    // R8
    buserr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_hit && rsp_err) |=> (res_valid && res_kind == RES_BUSERR));
    // R5
    dir_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DIR_WAIT && rsp_valid && !rsp_err && !present)
        |=> (res_valid && res_kind == RES_PFAULT));
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic [PA_W-1:0]   dir_base,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [PA_W-1:0]   mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic [PA_W-1:0]   res_paddr,
    output logic [VA_W-1:0]   res_vaddr,
    output logic              res_write
);
    logic               level, ld_req, ld_tbl, ld_page;
    logic               present, permitted;
    logic [FRAME_W-1:0] entry_frame;
    res_kind_e          kind;
    xlat_req_t          ctx, req;

    assign req = '{va: req_vaddr, wr: req_write};

    xlat_ctl u_ctl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .mem_rd_ready (mem_rd_ready),
        .rsp_valid    (mem_rsp_valid),
        .rsp_err      (mem_rsp_err),
        .present      (present),
        .permitted    (permitted),
        .req_ready    (req_ready),
        .mem_rd_valid (mem_rd_valid),
        .level        (level),
        .ld_req       (ld_req),
        .ld_tbl       (ld_tbl),
        .ld_page      (ld_page),
        .res_valid    (res_valid),
        .res_kind     (kind)
    );

    xlat_entry_chk u_chk (
        .data      (mem_rsp_data),
        .is_leaf   (level),
        .wr        (ctx.wr),
        .present   (present),
        .permitted (permitted),
        .frame     (entry_frame)
    );

    xlat_ctx u_ctx (
        .clk         (clk),
        .rst         (rst),
        .ld_req      (ld_req),
        .req         (req),
        .dir_frame   (dir_base[PA_W-1 -: FRAME_W]),
        .ld_tbl      (ld_tbl),
        .ld_page     (ld_page),
        .entry_frame (entry_frame),
        .level       (level),
        .rd_addr     (mem_rd_addr),
        .ctx         (ctx),
        .paddr       (res_paddr)
    );

    assign res_kind  = kind;
    assign res_vaddr = ctx.va;
    assign res_write = ctx.wr;

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
endmodule

// File: tb/test_xlat_walker.sv
module test_xlat_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] dir_base = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        res_valid;
    logic [1:0]  res_kind;
    logic [31:0] res_paddr;
    logic [31:0] res_vaddr;
    logic        res_write;

    always #5 clk = ~clk;

    xlat_walker i_xlat_walker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .dir_base(dir_base),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .res_valid(res_valid), .res_kind(res_kind), .res_paddr(res_paddr),
        .res_vaddr(res_vaddr), .res_write(res_write)
    );

    bit [31:0]  mem [bit [31:0]];
    bit [31:0]  exp_addr_q [$];
    int         checks = 0;
    int         errors = 0;
    int         err_at = 0;
    int         rd_cnt = 0;
    int         lat_cnt = 0;
    bit         rsp_pend = 0;
    bit         hs_next = 0;
    bit         rsp_err_flag = 0;
    bit [31:0]  rsp_addr = '0;
    bit [15:0]  lfsr = 16'hACE1;
    bit         prev_v = 0;
    bit         prev_r = 0;
    bit [31:0]  prev_a = '0;
    bit         finished = 0;

    function automatic bit [31:0] rd(input bit [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural table memory with variable acceptance and latency
    always @(negedge clk) begin
        if (rst) begin
            mem_rd_ready  = 1'b0;
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
        end else begin
            if (prev_v && !prev_r)
                chk(mem_rd_valid && mem_rd_addr == prev_a, "R10", "read held",
                    {mem_rd_valid, mem_rd_addr}, {1'b1, prev_a});
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            if (hs_next) begin
                hs_next  = 0;
                rsp_pend = 1;
                lat_cnt  = int'(lfsr % 3);
            end
            if (rsp_pend) begin
                if (lat_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(rsp_addr);
                    mem_rsp_err   = rsp_err_flag;
                    rsp_pend      = 0;
                end else begin
                    lat_cnt--;
                end
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_rd_ready = lfsr[0] | lfsr[3];
            if (mem_rd_valid && mem_rd_ready) begin
                bit [31:0] e;
                rd_cnt++;
                if (exp_addr_q.size() == 0) begin
                    chk(0, "R5", "unexpected read", mem_rd_addr, 0);
                end else begin
                    e = exp_addr_q.pop_front();
                    chk(mem_rd_addr == e, rd_cnt == 1 ? "R2" : "R3", "read address",
                        mem_rd_addr, e);
                end
                hs_next      = 1;
                rsp_addr     = mem_rd_addr;
                rsp_err_flag = (rd_cnt == err_at);
            end
            prev_v = mem_rd_valid;
            prev_r = mem_rd_ready;
            prev_a = mem_rd_addr;
        end
    end

    task automatic xlat(input bit [31:0] va, input bit wr, input bit [31:0] base,
                        input int errat, input string tag);
        bit [31:0] da, dte, pa, pte, exp_pa;
        bit [1:0]  exp_k;
        int        n;
        exp_pa = '0;
        da  = {base[31:12], va[31:22], 2'b00};
        dte = rd(da);
        exp_addr_q.push_back(da);
        if (errat == 1)      exp_k = 2'b10;
        else if (!dte[0])    exp_k = 2'b01;
        else begin
            pa  = {dte[31:12], va[21:12], 2'b00};
            pte = rd(pa);
            exp_addr_q.push_back(pa);
            if (errat == 2)                          exp_k = 2'b10;
            else if (!pte[0] || !(wr ? pte[2] : pte[1])) exp_k = 2'b01;
            else begin
                exp_k  = 2'b00;
                exp_pa = {pte[31:12], va[11:0]};
            end
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        err_at    = errat;
        rd_cnt    = 0;
        dir_base  = base;
        req_vaddr = va;
        req_write = wr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        dir_base  = 32'hDEAD_BEEF;
        n = 0;
        while (!res_valid && n < 60) begin
            chk(!req_ready, "R9", "ready low while busy", req_ready, 0);
            @(negedge clk);
            n++;
        end
        chk(res_valid, "R9", "result delivered", res_valid, 1);
        chk(res_kind == exp_k, tag, "result kind", res_kind, exp_k);
        chk(res_vaddr == va && res_write == wr, "R9", "result context",
            {res_vaddr, res_write}, {va, wr});
        if (exp_k == 2'b00)
            chk(res_paddr == exp_pa, "R4", "physical address", res_paddr, exp_pa);
        chk(!req_ready, "R9", "ready low in result cycle", req_ready, 0);
        chk(exp_addr_q.size() == 0, exp_k == 2'b10 ? "R8" : "R5", "reads pending",
            exp_addr_q.size(), 0);
        exp_addr_q.delete();
        @(negedge clk);
        chk(req_ready && !res_valid, "R9", "ready after result",
            {req_ready, res_valid}, 2'b10);
    endtask

    localparam bit [31:0] BASE0 = 32'h0010_0000;
    localparam bit [31:0] BASE1 = 32'h0070_0123;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R9 watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mem[BASE0 + 4]        = 32'h0020_0001;
        mem[BASE0 + 12]       = 32'h0030_0000;
        mem[BASE0 + 0]        = 32'h0050_0FFE;
        mem[BASE0 + 32'hFFC]  = 32'h0040_0001;
        mem[32'h0070_0004]    = 32'h0020_0001;
        mem[32'h0020_0000 + 12] = 32'h1234_5007;
        mem[32'h0020_0000 + 16] = 32'h5555_5006;
        mem[32'h0020_0000 + 20] = 32'h6666_6003;
        mem[32'h0020_0000 + 24] = 32'h7777_7005;
        mem[32'h0020_0000 + 28] = 32'h8888_8FF9;
        mem[32'h0020_0000 + 32] = 32'h9999_9E07;
        mem[32'h0040_0FFC]      = 32'hABCD_E003;

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        chk(mem_rd_valid == 1'b0, "R1", "no read in reset", mem_rd_valid, 0);
        chk(res_valid == 1'b0, "R1", "no result in reset", res_valid, 0);
        rst = 1'b0;

        xlat(32'h0040_3ABC, 0, BASE0, 0, "R4");
        xlat(32'h0040_3ABC, 1, BASE0, 0, "R4");
        xlat(32'h0040_3ABC, 0, BASE1, 0, "R2");
        xlat(32'hFFFF_FFFF, 0, BASE0, 0, "R4");
        xlat(32'h0080_0000, 0, BASE0, 0, "R5");
        xlat(32'h00C0_0010, 1, BASE0, 0, "R5");
        xlat(32'h0000_0000, 0, BASE0, 0, "R5");
        xlat(32'h0040_4000, 0, BASE0, 0, "R6");
        xlat(32'h0040_4123, 1, BASE0, 0, "R6");
        xlat(32'h0040_5FFF, 1, BASE0, 0, "R7");
        xlat(32'h0040_5FFF, 0, BASE0, 0, "R7");
        xlat(32'h0040_6010, 0, BASE0, 0, "R7");
        xlat(32'h0040_6010, 1, BASE0, 0, "R7");
        xlat(32'h0040_7000, 0, BASE0, 0, "R7");
        xlat(32'h0040_7000, 1, BASE0, 0, "R7");
        xlat(32'h0040_8765, 1, BASE0, 0, "R7");
        xlat(32'h0040_3ABC, 0, BASE0, 1, "R8");
        xlat(32'h0040_3ABC, 1, BASE0, 2, "R8");
        xlat(32'h0080_0000, 0, BASE0, 1, "R8");
        xlat(32'h0040_4000, 0, BASE0, 2, "R8");
        for (int i = 0; i < 24; i++) begin
            bit [31:0] v;
            v = {10'd1, 10'(3 + (i % 6)), 12'(i * 157)};
            xlat(v, i[0], (i % 3 == 0) ? BASE1 : BASE0, (i % 7 == 6) ? 2 : 0, "R3");
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule